// File: doc/BRIEF.md
# Two-Stage Pipelined Move-Only Processor Core

This block is a small byte-addressed processor that runs four instructions: halt, nop, an immediate-to-register move and a register-to-register move. It has two stages. The front stage fetches, decodes and reads the register file in one cycle. A single pipeline register then carries the work to the writeback stage, which updates the register file on the clock edge that ends its cycle. Instruction memory is external. The core shows its program counter on a fetch address and receives the six bytes that start at that address.

A writeback that is still pending can name the register that the front stage is reading in the same cycle. This is a read-after-write hazard, and a build-time parameter chooses how it is resolved. With `HAZARD_FWD = 0` the core holds the program counter and inserts a bubble into the pipeline register. With `HAZARD_FWD = 1` it passes the pending writeback value directly into the latched source value. Writebacks are also shown on a dedicated writeback port, and any register can be read through a probe port.

Top module: `mini_pipe_core`

## Requirements
- R1: While reset is held and in the first cycle after it, pc = 0, stat = 1 (ok), halted = 0 and wb_en = 0, and every register reads 0 through the probe port.
- R2: The byte 0x30 followed by a byte 0xF:rB and a 32-bit little-endian immediate (6 bytes) writes the immediate into register rB. Register ids are 0 to 7 (eax=0, ecx=1, edx=2, ebx=3, esp=4, ebp=5, esi=6, edi=7), and 0xF means none.
- R3: The byte 0x20 followed by a byte rA:rB (2 bytes, rA in the high nibble) copies register rA into register rB.
- R4: imem_addr equals pc. In each cycle that is neither stalled nor halted, pc advances by the length of the fetched instruction: 1 byte for halt (0x00) and nop (0x10), 2 for the register move, 6 for the immediate move.
- R5: A register write is shown on wb_en/wb_reg/wb_data in the cycle after its instruction is fetched, and it lands in the register file at the end of that cycle. Writes occur in program order.
- R6: With HAZARD_FWD=0, a pending write whose destination matches the source being read holds pc for one cycle and puts a bubble into writeback. For "irmovl $1,%eax; rrmovl %eax,%ebx; halt", halted first rises in cycle 5.
- R7: With HAZARD_FWD=1, the pending write value is used in place of the stale register read, and nothing stalls. The same program halts in cycle 4.
- R8: For "irmovl $0x162e,%eax; irmovl $0x22,%ecx; rrmovl %eax,%edx; rrmovl %ecx,%eax; halt", halted first rises in cycle 6 in both modes. The result is eax=0x22, ecx=0x22, edx=0x162e, ebx=0 and pc=0x11.
- R9: When a halt reaches writeback, stat = 2 and halted = 1. From then on pc, stat and the registers stay frozen and no write occurs.
- R10: Any first byte other than 0x00, 0x10, 0x20 or 0x30 gives stat = 4 when it reaches writeback, then halts like R9 with no register write. Its length counts as 1 byte.
- R11: A nop writes no register and only advances pc by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | PC_W | Fetch address (equals pc) |
| imem_bytes | input | 48 | Six instruction bytes starting at imem_addr, first byte in bits 7:0 |
| probe_idx | input | log2(NREGS) | Register selected for the probe port |
| probe_data | output | 32 | Current content of the probed register |
| wb_en | output | 1 | A register write takes place at the end of this cycle |
| wb_reg | output | log2(NREGS) | Register being written |
| wb_data | output | 32 | Value being written |
| pc | output | PC_W | Program counter of the front stage |
| stat | output | 3 | Status of the instruction in writeback: 1 ok, 2 halt, 4 invalid |
| halted | output | 1 | The core is frozen on a halt or an invalid instruction |

## Verification
Each result has a fixed cycle in which it is due, counted from cycle 1, the first cycle after reset is released. A register write appears on the writeback port one cycle after its fetch and shows through the probe one edge later. pc shows the next fetch address one edge after each fetch, and halted rises in the cycle after the halt (or invalid byte) is fetched. The bench drives inputs on falling edges and samples 1 ns after them. It records pc, wb_en and halted for every cycle of a run and compares them against the cycle numbers worked out above, so a stall or a forward shows up as a one-cycle shift in pc and in the halt cycle. A scoreboard queue holds the expected writes in program order, and the monitor pops one entry for every cycle in which wb_en is high.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int WORD_W  = 32;
  localparam int FETCH_N = 6;
  localparam int FETCH_W = 8 * FETCH_N;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_RRMOV = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;

  localparam logic [3:0] RID_NONE = 4'hF;

  localparam logic [2:0] ST_OK  = 3'd1;
  localparam logic [2:0] ST_HLT = 3'd2;
  localparam logic [2:0] ST_INS = 3'd4;

  typedef struct packed {
    logic [3:0]        op;
    logic [WORD_W-1:0] imm;
    logic [WORD_W-1:0] srcval;
    logic [3:0]        dst;
    logic [2:0]        st;
  } wb_slot_t;

  function automatic wb_slot_t slot_bubble();
    wb_slot_t b;
    b.op     = OP_NOP;
    b.imm    = '0;
    b.srcval = '0;
    b.dst    = RID_NONE;
    b.st     = ST_OK;
    return b;
  endfunction

  function automatic logic [2:0] op_length(input logic [3:0] op, input logic ok);
    if (!ok) return 3'd1;
    case (op)
      OP_RRMOV: return 3'd2;
      OP_IRMOV: return 3'd6;
      default:  return 3'd1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] slot_result(input wb_slot_t s);
    return (s.op == OP_IRMOV) ? s.imm : s.srcval;
  endfunction
endpackage

// File: rtl/mp_decode.sv
module mp_decode
  import mp_pkg::*;
(
  input  logic [FETCH_W-1:0] bytes,
  output logic [3:0]         op,
  output logic [3:0]         src_id,
  output logic [3:0]         dst_id,
  output logic [WORD_W-1:0]  imm,
  output logic [2:0]         len,
  output logic [2:0]         st
);
  logic [7:0] b0;
  logic [7:0] b1;
  logic       known;
  logic       writes;

  assign b0     = bytes[7:0];
  assign b1     = bytes[15:8];
  assign imm    = bytes[FETCH_W-1:16];
  assign known  = (b0[3:0] == 4'h0) && (b0[7:4] <= OP_IRMOV);
  assign writes = known && ((b0[7:4] == OP_RRMOV) || (b0[7:4] == OP_IRMOV));

  always_comb begin
    op     = known ? b0[7:4] : OP_NOP;
    src_id = (known && b0[7:4] == OP_RRMOV) ? b1[7:4] : RID_NONE;
    dst_id = writes ? b1[3:0] : RID_NONE;
    len    = op_length(b0[7:4], known);
    if (!known)                st = ST_INS;
    else if (b0[7:4] == OP_HALT) st = ST_HLT;
    else                       st = ST_OK;
  end
endmodule

// File: rtl/mp_regfile.sv
module mp_regfile
  import mp_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_id,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic [WORD_W-1:0] probe_data,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_data    = (int'(rd_id) < NREGS) ? regs[rd_id[IDX_W-1:0]] : '0;
  assign probe_data = regs[probe_idx];
endmodule

// File: rtl/mp_hazard.sv
module mp_hazard
  import mp_pkg::*;
#(
  parameter bit HAZARD_FWD = 1'b0
) (
  input  logic [3:0]        pend_dst,
  input  logic [WORD_W-1:0] pend_val,
  input  logic [3:0]        src_id,
  input  logic [WORD_W-1:0] rf_val,
  output logic              stall_evt,
  output logic              fwd_evt,
  output logic [WORD_W-1:0] src_val
);
  logic clash;
  assign clash = (pend_dst != RID_NONE) && (pend_dst == src_id);

  generate
    if (HAZARD_FWD) begin : g_bypass
      assign stall_evt = 1'b0;
      assign fwd_evt   = clash;
    end else begin : g_interlock
      assign stall_evt = clash;
      assign fwd_evt   = 1'b0;
    end
  endgenerate

  assign src_val = fwd_evt ? pend_val : rf_val;
endmodule

// File: rtl/mini_pipe_core.sv
module mini_pipe_core
  import mp_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int NREGS      = 8,
  parameter bit HAZARD_FWD = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [PC_W-1:0]          imem_addr,
  input  logic [FETCH_W-1:0]       imem_bytes,
  input  logic [$clog2(NREGS)-1:0] probe_idx,
  output logic [WORD_W-1:0]        probe_data,
  output logic                     wb_en,
  output logic [$clog2(NREGS)-1:0] wb_reg,
  output logic [WORD_W-1:0]        wb_data,
  output logic [PC_W-1:0]          pc,
  output logic [2:0]               stat,
  output logic                     halted
);
  localparam int IDX_W = $clog2(NREGS);

  wb_slot_t          slot_q, slot_d;
  logic [3:0]        fd_op, fd_src, fd_dst;
  logic [WORD_W-1:0] fd_imm, rf_val, src_val;
  logic [2:0]        fd_len, fd_st;
  logic              stall_evt, fwd_evt;

  mp_decode u_dec (
    .bytes (imem_bytes),
    .op    (fd_op),
    .src_id(fd_src),
    .dst_id(fd_dst),
    .imm   (fd_imm),
    .len   (fd_len),
    .st    (fd_st)
  );

  mp_regfile #(.NREGS(NREGS)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .rd_id     (fd_src),
    .rd_data   (rf_val),
    .probe_idx (probe_idx),
    .probe_data(probe_data),
    .we        (wb_en),
    .wr_idx    (wb_reg),
    .wr_data   (wb_data)
  );

  mp_hazard #(.HAZARD_FWD(HAZARD_FWD)) u_haz (
    .pend_dst (slot_q.dst),
    .pend_val (wb_data),
    .src_id   (fd_src),
    .rf_val   (rf_val),
    .stall_evt(stall_evt),
    .fwd_evt  (fwd_evt),
    .src_val  (src_val)
  );

  always_comb begin
    slot_d.op     = fd_op;
    slot_d.imm    = fd_imm;
    slot_d.srcval = src_val;
    slot_d.dst    = fd_dst;
    slot_d.st     = fd_st;
  end

  assign halted    = (slot_q.st != ST_OK);
  assign stat      = slot_q.st;
  assign imem_addr = pc;
  assign wb_en     = (slot_q.dst != RID_NONE) && (int'(slot_q.dst) < NREGS);
  assign wb_reg    = slot_q.dst[IDX_W-1:0];
  assign wb_data   = slot_result(slot_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      slot_q <= slot_bubble();
    end else if (!halted) begin
      if (stall_evt) begin
        slot_q <= slot_bubble();
      end else begin
        slot_q <= slot_d;
        pc     <= pc + PC_W'(fd_len);
      end
    end
  end
endmodule

// File: rtl/mp_core_chk.sv
module mp_core_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pc,
  input logic [2:0]      stat,
  input logic            halted,
  input logic            stall_evt,
  input logic            wb_en
);
  assert_stall_holds_pc_R6: assert property (@(posedge clk) disable iff (rst)
    (stall_evt && !halted) |=> ($stable(pc) && !wb_en));

  assert_pc_advances_R4: assert property (@(posedge clk) disable iff (rst)
    (!halted && !stall_evt) |=> (pc != $past(pc)));

  assert_halt_freezes_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(stat)));

  assert_no_write_halted_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> !wb_en);

  assert_stat_legal_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stat) && (stat != 3'd0));
endmodule

bind mini_pipe_core mp_core_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc),
  .stat     (stat),
  .halted   (halted),
  .stall_evt(stall_evt),
  .wb_en    (wb_en)
);

// File: tb/mini_pipe_core_tb.sv
`timescale 1ns/1ps
module mini_pipe_core_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0]  mem [256];
  logic [15:0] a_s, a_f, pc_s, pc_f;
  logic [47:0] by_s, by_f;
  logic [2:0]  probe_idx = '0;
  logic [31:0] pd_s, pd_f, wd_s, wd_f;
  logic        we_s, we_f, h_s, h_f;
  logic [2:0]  wr_s, wr_f, st_s, st_f;

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      by_s[8*i +: 8] = mem[8'(a_s + 16'(i))];
      by_f[8*i +: 8] = mem[8'(a_f + 16'(i))];
    end
  end

  mini_pipe_core #(.HAZARD_FWD(1'b0)) u_dut (
    .clk(clk), .rst(rst), .imem_addr(a_s), .imem_bytes(by_s),
    .probe_idx(probe_idx), .probe_data(pd_s), .wb_en(we_s), .wb_reg(wr_s),
    .wb_data(wd_s), .pc(pc_s), .stat(st_s), .halted(h_s));

  mini_pipe_core #(.HAZARD_FWD(1'b1)) u_dut_fwd (
    .clk(clk), .rst(rst), .imem_addr(a_f), .imem_bytes(by_f),
    .probe_idx(probe_idx), .probe_data(pd_f), .wb_en(we_f), .wb_reg(wr_f),
    .wb_data(wd_f), .pc(pc_f), .stat(st_f), .halted(h_f));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard queues: {reg, data}
  logic [34:0] q_s[$];
  logic [34:0] q_f[$];

  task automatic exp_wr(input logic [2:0] r, input logic [31:0] d);
    q_s.push_back({r, d});
    q_f.push_back({r, d});
  endtask

  task automatic put(input int addr, input logic [7:0] b);
    mem[addr] = b;
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (we_s) begin
        if (q_s.size() == 0) chk(1'b0, "R5", "stall unexpected write", {wr_s, wd_s[28:0]}, 0);
        else begin
          logic [34:0] e;
          e = q_s.pop_front();
          chk({wr_s, wd_s} == e, "R5", "stall write", {29'b0, wr_s} ^ wd_s, e[31:0]);
        end
      end
      if (we_f) begin
        if (q_f.size() == 0) chk(1'b0, "R5", "fwd unexpected write", {wr_f, wd_f[28:0]}, 0);
        else begin
          logic [34:0] e;
          e = q_f.pop_front();
          chk({wr_f, wd_f} == e, "R5", "fwd write", {29'b0, wr_f} ^ wd_f, e[31:0]);
        end
      end
    end
  end

  int cyc;
  int hc_s, hc_f;
  logic [15:0] hist_s [64];
  logic [15:0] hist_f [64];
  logic        wbh_s  [64];

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(pc_s == 0 && pc_f == 0, "R1", "pc in reset", {pc_s, pc_f}, 0);
    chk(st_s == 3'd1 && st_f == 3'd1, "R1", "stat in reset", {st_s, st_f}, 32'h9);
    chk(!h_s && !h_f && !we_s && !we_f, "R1", "halted/wb in reset",
        {h_s, h_f, we_s, we_f}, 0);
    for (int r = 0; r < 8; r++) begin
      probe_idx = 3'(r);
      #0.1;
      chk(pd_s == 0 && pd_f == 0, "R1", "register cleared", pd_s | pd_f, 0);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_prog();
    do_reset();
    cyc = 1; hc_s = 0; hc_f = 0;
    #1;
    chk(!we_s && !we_f, "R1", "no write in cycle 1", {we_s, we_f}, 0);
    while (cyc < 60) begin
      hist_s[cyc] = pc_s;
      hist_f[cyc] = pc_f;
      wbh_s[cyc]  = we_s;
      chk(a_s == pc_s && a_f == pc_f, "R4", "imem_addr equals pc", a_s, pc_s);
      if (hc_s == 0 && h_s) hc_s = cyc;
      if (hc_f == 0 && h_f) hc_f = cyc;
      if (hc_s != 0 && hc_f != 0) break;
      @(negedge clk);
      #1;
      cyc++;
    end
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic fin(input int cs, input int cf, input logic [15:0] epc,
                     input logic [2:0] est, input string req);
    chk(hc_s == cs, req, "stall halt cycle", hc_s, cs);
    chk(hc_f == cf, req, "fwd halt cycle", hc_f, cf);
    chk(pc_s == epc && pc_f == epc, "R9", "frozen pc", {pc_s, pc_f}, {epc, epc});
    chk(st_s == est && st_f == est, req, "final stat", {st_s, st_f}, {est, est});
    chk(h_s && h_f, "R9", "halted held", {h_s, h_f}, 3);
    chk(q_s.size() == 0 && q_f.size() == 0, "R5", "all writes seen",
        q_s.size() + q_f.size(), 0);
  endtask

  task automatic reg_is(input int r, input logic [31:0] v, input string req);
    probe_idx = 3'(r);
    #0.1;
    chk(pd_s == v, req, "stall register value", pd_s, v);
    chk(pd_f == v, req, "fwd register value", pd_f, v);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected<=100000", wd);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    // Program A: four moves then halt (R2, R3, R4, R8)
    clear_mem();
    put(0, 8'h30); put(1, 8'hF0); put(2, 8'h2E); put(3, 8'h16); put(4, 8'h00); put(5, 8'h00);
    put(6, 8'h30); put(7, 8'hF1); put(8, 8'h22); put(9, 8'h00); put(10, 8'h00); put(11, 8'h00);
    put(12, 8'h20); put(13, 8'h02);
    put(14, 8'h20); put(15, 8'h10);
    put(16, 8'h00);
    exp_wr(3'd0, 32'h162e); exp_wr(3'd1, 32'h22); exp_wr(3'd2, 32'h162e); exp_wr(3'd0, 32'h22);
    run_prog();
    fin(6, 6, 16'h11, 3'd2, "R8");
    chk(hist_s[2] == 6 && hist_f[2] == 6, "R4", "pc after 6-byte move", hist_s[2], 6);
    chk(hist_s[4] == 14 && hist_f[4] == 14, "R4", "pc after 2-byte move", hist_s[4], 14);
    reg_is(0, 32'h22, "R8");
    reg_is(1, 32'h22, "R2");
    reg_is(2, 32'h162e, "R3");
    reg_is(3, 32'h0, "R8");

    // Program B: dependent move (R6, R7)
    clear_mem();
    put(0, 8'h30); put(1, 8'hF0); put(2, 8'h01); put(3, 8'h00); put(4, 8'h00); put(5, 8'h00);
    put(6, 8'h20); put(7, 8'h03);
    put(8, 8'h00);
    exp_wr(3'd0, 32'h1); exp_wr(3'd3, 32'h1);
    run_prog();
    fin(5, 4, 16'h9, 3'd2, "R6");
    chk(hist_s[3] == 6, "R6", "stall holds pc in cycle 3", hist_s[3], 6);
    chk(hist_f[3] == 8, "R7", "forward keeps pc moving", hist_f[3], 8);
    reg_is(0, 32'h1, "R7");
    reg_is(3, 32'h1, "R7");

    // Program C: nops, dependent move, invalid opcode (R10, R11)
    clear_mem();
    put(0, 8'h10); put(1, 8'h10);
    put(2, 8'h30); put(3, 8'hF6); put(4, 8'hA5); put(5, 8'hA5); put(6, 8'h00); put(7, 8'h00);
    put(8, 8'h20); put(9, 8'h67);
    put(10, 8'hF0);
    exp_wr(3'd6, 32'hA5A5); exp_wr(3'd7, 32'hA5A5);
    run_prog();
    fin(7, 6, 16'h0B, 3'd4, "R10");
    chk(hist_s[2] == 1 && hist_s[3] == 2, "R11", "nop advances by 1", hist_s[3], 2);
    chk(!wbh_s[2] && !wbh_s[3], "R11", "nop writes nothing", {wbh_s[2], wbh_s[3]}, 0);
    reg_is(6, 32'hA5A5, "R2");
    reg_is(7, 32'hA5A5, "R6");
    reg_is(0, 32'h0, "R10");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule